// File: doc/BRIEF.md
# Mode-Aware Transfer FIFO with Size Tracking

This block is the byte store that sits between a serial bus controller's processor interface and its bit-level engine. One 16-entry, 8-bit FIFO serves whichever direction is active. In a transmit mode the processor pushes bytes and the engine drains them. In a receive mode the engine pushes bytes and the processor reads them. Strobes that belong to the inactive direction are ignored.

A 6-bit transfer-size register sits beside the FIFO. What it holds depends on the operating mode:
- As master transmitter it counts the bytes still to be sent, minus one.
- As master receiver it counts the bytes still expected.
- As slave transmitter it captures the bytes left over when the remote master stops.
- As slave receiver it mirrors the FIFO occupancy.

The block also raises sticky error flags, a one-cycle pulse when the FIFO first holds 14 bytes, and per-direction data-valid levels. A self-clearing clear request empties everything.

The engine is not part of this block. It is seen only through its push, pop and end-of-transfer strobes.

Top module: `xfer_fifo_ctl`

## Requirements
- R1: After reset the FIFO is empty, the size register reads 0, all three error flags, the threshold pulse, both data-valid bits and the clear-pending bit are 0, and the CPU read data is 0.
- R2: Bytes leave in the order they entered, up to 16 held. In transmit modes the engine reads the oldest byte on `eng_pop_data` and removes it with `eng_pop`. In receive modes `cpu_rd_en` removes the oldest byte, and that byte appears on `cpu_rd_data` after the same clock edge.
- R3: A CPU write in a transmit mode while 16 bytes are held is dropped and sets `tx_ovf`. The flag stays set until a clear.
- R4: An engine push in a receive mode while 16 bytes are held is dropped and sets `rx_ovf`. The flag stays set until a clear.
- R5: A CPU read in a receive mode while the FIFO is empty loads 0 into `cpu_rd_data` and sets `rx_unf`. The flag stays set until a clear.
- R6: In master-transmit mode (`mode`=2'b10) each accepted engine pop lowers the size register by one, stopping at 0.
- R7: In master-receive mode (`mode`=2'b11) each accepted engine push lowers the size register by one, stopping at 0. A dropped push leaves it unchanged.
- R8: In slave-transmit mode (`mode`=2'b00) an `eng_done` strobe loads the size register with the number of bytes left in the FIFO.
- R9: In slave-receive mode (`mode`=2'b01) the size register equals the FIFO occupancy after every edge, and CPU writes to it have no effect.
- R10: `thresh_evt` is high for exactly one cycle: the first cycle in which the occupancy has just become 14.
- R11: A `clr_req` pulse sets `clr_pending` after that edge. At the following edge the FIFO empties, the size register and all error flags go to 0, and `clr_pending` drops by itself.
- R12: `tx_dv` is high when a transmit mode is selected (`mode[0]`=0) and the FIFO is not empty. `rx_dv` is high when a receive mode is selected (`mode[0]`=1) and the FIFO is not empty.
- R13: In transmit modes `eng_push` and `cpu_rd_en` leave the FIFO untouched. In receive modes `cpu_wr_en` and `eng_pop` leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bit 1: master (1) or slave (0). Bit 0: receive (1) or transmit (0) |
| cpu_wr_en | input | 1 | CPU data write strobe (push in transmit modes) |
| cpu_wr_data | input | 8 | CPU write byte |
| cpu_rd_en | input | 1 | CPU data read strobe (pop in receive modes) |
| cpu_rd_data | output | 8 | Byte returned by the last CPU read |
| size_wr_en | input | 1 | CPU write strobe for the size register |
| size_wr_data | input | 6 | Value written to the size register |
| size_q | output | 6 | Transfer-size register |
| clr_req | input | 1 | Request to clear FIFO and size |
| clr_pending | output | 1 | Self-clearing clear bit |
| eng_push | input | 1 | Engine pushes a received byte |
| eng_push_data | input | 8 | Received byte |
| eng_pop | input | 1 | Engine takes the oldest byte for sending |
| eng_pop_data | output | 8 | Oldest byte, 0 when empty |
| eng_done | input | 1 | Remote master ended the transfer |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| thresh_evt | output | 1 | One-cycle pulse when occupancy reaches 14 |
| tx_dv | output | 1 | Transmit data valid |
| rx_dv | output | 1 | Receive data valid |

## Verification
Each of the four modes is driven through a full fill-and-drain cycle using a byte pattern computed from the index. This shows whether ordering, size arithmetic and mode decode stay correct at every occupancy from 0 to 16.

Every fill runs one step past full, and every drain runs one step past empty. These extra steps separate dropped operations from counted ones and show which flag each one sets.

Strobes from the inactive direction are injected mid-sequence. Their absence of effect is read back through the size register, the data-valid bits and the order of the data that follows.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  typedef enum logic [1:0] {
    MODE_STX = 2'b00,
    MODE_SRX = 2'b01,
    MODE_MTX = 2'b10,
    MODE_MRX = 2'b11
  } xfer_mode_e;

  function automatic logic mode_is_rx(input logic [1:0] m);
    return m[0];
  endfunction

  // decrement that holds at zero
  function automatic logic [31:0] dec_floor(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction

  // occupancy after one edge with optional push and pop
  function automatic logic [31:0] occ_after(input logic [31:0] occ,
                                            input logic push,
                                            input logic pop);
    return occ + {31'd0, push} - {31'd0, pop};
  endfunction

  // pointer advance with wrap at depth
  function automatic logic [31:0] ptr_adv(input logic [31:0] p,
                                          input logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_next_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign head_o  = empty_o ? '0 : mem[rd_ptr_q];
  assign count_next_o = clr_i ? '0
                      : CW'(occ_after(32'(count_q), do_push, do_pop));
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      count_q <= count_next_o;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= AW'(ptr_adv(32'(wr_ptr_q), 32'(DEPTH)));
        if (do_pop)  rd_ptr_q <= AW'(ptr_adv(32'(rd_ptr_q), 32'(DEPTH)));
      end
    end
  end

  // R2: occupancy never exceeds depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R11: a clear leaves the store empty
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0));

  // R3/R4: a push into a full store without a pop leaves occupancy alone
  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !clr_i) |=> (count_q == CW'(DEPTH)));

endmodule

// File: rtl/xfer_fifo_size.sv
module xfer_fifo_size
  import xfer_fifo_pkg::*;
#(
  parameter int SW = 6,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [1:0]    mode_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_data_i,
  input  logic          tx_pop_ok_i,
  input  logic          rx_push_ok_i,
  input  logic          done_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] count_next_i,
  output logic [SW-1:0] size_o
);

  logic [SW-1:0] size_q, size_d, size_dec;
  xfer_mode_e    md;

  assign md       = xfer_mode_e'(mode_i);
  assign size_dec = SW'(dec_floor(32'(size_q)));

  always_comb begin
    size_d = size_q;
    if (clr_i)                size_d = '0;
    else if (md == MODE_SRX)  size_d = SW'(count_next_i);
    else if (wr_en_i)         size_d = wr_data_i;
    else begin
      unique case (md)
        MODE_MTX: if (tx_pop_ok_i)  size_d = size_dec;
        MODE_MRX: if (rx_push_ok_i) size_d = size_dec;
        MODE_STX: if (done_i)       size_d = SW'(count_next_i);
        default:  size_d = size_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else        size_q <= size_d;
  end

  assign size_o = size_q;

  // R9: slave-receive size follows the store's occupancy
  assert_slave_rx_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !clr_i) |=> (size_q == SW'(count_i)));

  // R7: an accepted receive push in master-receive lowers a nonzero size by one
  assert_mrx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !clr_i && !wr_en_i && rx_push_ok_i && size_q != '0)
      |=> (size_q == $past(size_q) - SW'(1)));

  // R6: master-transmit size holds at zero on further pops
  assert_mtx_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !clr_i && !wr_en_i && size_q == '0) |=> (size_q == '0));

endmodule

// File: rtl/xfer_fifo_flags.sv
module xfer_fifo_flags
  import xfer_fifo_pkg::*;
#(
  parameter int CW     = 5,
  parameter int THRESH = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rx_mode_i,
  input  logic          tx_ovf_evt_i,
  input  logic          rx_ovf_evt_i,
  input  logic          rx_unf_evt_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] count_next_i,
  output logic          tx_ovf_o,
  output logic          rx_ovf_o,
  output logic          rx_unf_o,
  output logic          thresh_o,
  output logic          tx_dv_o,
  output logic          rx_dv_o
);

  logic tx_ovf_q, rx_ovf_q, rx_unf_q, thresh_q;
  logic thresh_arrive;

  assign thresh_arrive = (count_next_i == CW'(THRESH)) && (count_i != CW'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
      thresh_q <= 1'b0;
    end else if (clr_i) begin
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
      thresh_q <= 1'b0;
    end else begin
      tx_ovf_q <= tx_ovf_q | tx_ovf_evt_i;
      rx_ovf_q <= rx_ovf_q | rx_ovf_evt_i;
      rx_unf_q <= rx_unf_q | rx_unf_evt_i;
      thresh_q <= thresh_arrive;
    end
  end

  assign tx_ovf_o = tx_ovf_q;
  assign rx_ovf_o = rx_ovf_q;
  assign rx_unf_o = rx_unf_q;
  assign thresh_o = thresh_q;
  assign tx_dv_o  = !rx_mode_i && (count_i != '0);
  assign rx_dv_o  = rx_mode_i && (count_i != '0);

  // R10: the pulse only appears while the store holds the threshold count
  assert_thresh_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_q |-> (count_i == CW'(THRESH)));

  // R10: never two cycles in a row
  assert_thresh_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_q |=> !thresh_q);

  // R3: transmit overflow stays until a clear
  assert_tx_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_q && !clr_i) |=> tx_ovf_q);

  // R4: receive overflow stays until a clear
  assert_rx_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_q && !clr_i) |=> rx_ovf_q);

endmodule

// File: rtl/xfer_fifo_ctl.sv
module xfer_fifo_ctl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  parameter int SW     = 6,
  parameter int THRESH = 14,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          cpu_wr_en,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          cpu_rd_en,
  output logic [DW-1:0] cpu_rd_data,
  input  logic          size_wr_en,
  input  logic [SW-1:0] size_wr_data,
  output logic [SW-1:0] size_q,
  input  logic          clr_req,
  output logic          clr_pending,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_push_data,
  input  logic          eng_pop,
  output logic [DW-1:0] eng_pop_data,
  input  logic          eng_done,
  output logic          tx_ovf,
  output logic          rx_ovf,
  output logic          rx_unf,
  output logic          thresh_evt,
  output logic          tx_dv,
  output logic          rx_dv
);

  // named internal events
  logic          rx_mode, clr_go;
  logic          push_req, pop_req, push_ok, pop_ok;
  logic          tx_ovf_evt, rx_ovf_evt, rx_unf_evt;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] count, count_next;
  logic          full, empty;
  logic          clr_q;
  logic [DW-1:0] rd_q;

  assign rx_mode   = mode_is_rx(mode);
  assign clr_go    = clr_q;
  assign push_req  = rx_mode ? eng_push : cpu_wr_en;
  assign push_data = rx_mode ? eng_push_data : cpu_wr_data;
  assign pop_req   = rx_mode ? cpu_rd_en : eng_pop;
  assign push_ok   = push_req && !full && !clr_go;
  assign pop_ok    = pop_req && !empty && !clr_go;

  assign tx_ovf_evt = !rx_mode && cpu_wr_en && full;
  assign rx_ovf_evt = rx_mode && eng_push && full;
  assign rx_unf_evt = rx_mode && cpu_rd_en && empty;

  xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_go),
    .push_i       (push_req),
    .push_data_i  (push_data),
    .pop_i        (pop_req),
    .head_o       (head),
    .count_o      (count),
    .count_next_o (count_next),
    .full_o       (full),
    .empty_o      (empty)
  );

  xfer_fifo_size #(.SW(SW), .CW(CW)) u_size (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_go),
    .mode_i       (mode),
    .wr_en_i      (size_wr_en),
    .wr_data_i    (size_wr_data),
    .tx_pop_ok_i  (pop_ok && !rx_mode),
    .rx_push_ok_i (push_ok && rx_mode),
    .done_i       (eng_done),
    .count_i      (count),
    .count_next_i (count_next),
    .size_o       (size_q)
  );

  xfer_fifo_flags #(.CW(CW), .THRESH(THRESH)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_go),
    .rx_mode_i    (rx_mode),
    .tx_ovf_evt_i (tx_ovf_evt),
    .rx_ovf_evt_i (rx_ovf_evt),
    .rx_unf_evt_i (rx_unf_evt),
    .count_i      (count),
    .count_next_i (count_next),
    .tx_ovf_o     (tx_ovf),
    .rx_ovf_o     (rx_ovf),
    .rx_unf_o     (rx_unf),
    .thresh_o     (thresh_evt),
    .tx_dv_o      (tx_dv),
    .rx_dv_o      (rx_dv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      clr_q <= clr_req && !clr_q;
      if (rx_mode && cpu_rd_en) rd_q <= head;
    end
  end

  assign cpu_rd_data  = rd_q;
  assign clr_pending  = clr_q;
  assign eng_pop_data = rx_mode ? '0 : head;

  // R5: an empty read returns zero
  assert_unf_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf_evt |=> (cpu_rd_data == '0));

  // R11: the clear bit drops by itself
  assert_clr_self_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

  // R13: in a transmit mode the engine push never lands
  assert_tx_ignores_push_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && eng_push && !cpu_wr_en && !eng_pop && !clr_go) |=> $stable(count));

endmodule

// File: tb/tb_xfer_fifo_ctl.sv
module tb_xfer_fifo_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, size_wr_en = 1'b0, clr_req = 1'b0;
  logic [7:0] cpu_wr_data = '0, eng_push_data = '0;
  logic [5:0] size_wr_data = '0;
  logic       eng_push = 1'b0, eng_pop = 1'b0, eng_done = 1'b0;
  logic [7:0] cpu_rd_data, eng_pop_data;
  logic [5:0] size_q;
  logic       clr_pending, tx_ovf, rx_ovf, rx_unf, thresh_evt, tx_dv, rx_dv;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xfer_fifo_ctl dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .size_wr_en(size_wr_en), .size_wr_data(size_wr_data), .size_q(size_q),
    .clr_req(clr_req), .clr_pending(clr_pending),
    .eng_push(eng_push), .eng_push_data(eng_push_data),
    .eng_pop(eng_pop), .eng_pop_data(eng_pop_data), .eng_done(eng_done),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
    .thresh_evt(thresh_evt), .tx_dv(tx_dv), .rx_dv(rx_dv)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one edge, then strobes return low away from the edge
  task automatic tick();
    @(posedge clk);
    #1;
    cpu_wr_en = 0; cpu_rd_en = 0; size_wr_en = 0; clr_req = 0;
    eng_push = 0; eng_pop = 0; eng_done = 0;
  endtask

  task automatic do_clear();
    clr_req = 1; tick();
    check("R11", "pending", 32'(clr_pending), 1);
    tick();
    check("R11", "pending drop", 32'(clr_pending), 0);
    check("R11", "size", 32'(size_q), 0);
    check("R11", "flags", {29'd0, tx_ovf, rx_ovf, rx_unf}, 0);
    check("R11", "dv", {30'd0, tx_dv, rx_dv}, 0);
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 37 + salt * 11 + 5) & 255);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check("R1", "size", 32'(size_q), 0);
    check("R1", "flags", {27'd0, tx_ovf, rx_ovf, rx_unf, thresh_evt, clr_pending}, 0);
    check("R1", "dv", {30'd0, tx_dv, rx_dv}, 0);
    check("R1", "rd data", 32'(cpu_rd_data), 0);

    // master transmit: size 15 means 16 bytes
    mode = 2'b10;
    size_wr_en = 1; size_wr_data = 6'd15; tick();
    check("R6", "size load", 32'(size_q), 15);
    for (int k = 1; k <= 17; k++) begin
      cpu_wr_en = 1; cpu_wr_data = pat(k - 1, 0); tick();
      check("R10", "thresh on fill", 32'(thresh_evt), (k == 14) ? 1 : 0);
      check("R3", "tx_ovf", 32'(tx_ovf), (k == 17) ? 1 : 0);
      check("R12", "tx_dv", 32'(tx_dv), 1);
    end
    check("R12", "rx_dv in tx", 32'(rx_dv), 0);
    // R13: engine push and CPU read ignored in transmit mode
    eng_push = 1; eng_push_data = 8'hEE; tick();
    cpu_rd_en = 1; tick();
    for (int i = 0; i < 16; i++) begin
      check("R2", "tx order", 32'(eng_pop_data), 32'(pat(i, 0)));
      eng_pop = 1; tick();
      check("R6", "mtx size", 32'(size_q), (i < 15) ? 14 - i : 0);
    end
    check("R13", "dropped 17th and foreign push", 32'(tx_dv), 0);
    check("R3", "tx_ovf held", 32'(tx_ovf), 1);
    eng_pop = 1; tick();
    check("R6", "mtx floor", 32'(size_q), 0);
    do_clear();

    // master receive
    mode = 2'b11;
    size_wr_en = 1; size_wr_data = 6'd20; tick();
    for (int i = 0; i < 17; i++) begin
      eng_push = 1; eng_push_data = pat(i, 1); tick();
      check("R7", "mrx size", 32'(size_q), (i < 16) ? 19 - i : 4);
      check("R4", "rx_ovf", 32'(rx_ovf), (i == 16) ? 1 : 0);
      check("R12", "rx_dv", 32'(rx_dv), 1);
    end
    check("R12", "tx_dv in rx", 32'(tx_dv), 0);
    // R13: engine pop and CPU write ignored in receive mode
    eng_pop = 1; tick();
    cpu_wr_en = 1; cpu_wr_data = 8'h77; tick();
    for (int i = 0; i < 16; i++) begin
      cpu_rd_en = 1; tick();
      check("R2", "rx order", 32'(cpu_rd_data), 32'(pat(i, 1)));
    end
    check("R13", "rx empty after 16", 32'(rx_dv), 0);
    check("R5", "no unf yet", 32'(rx_unf), 0);
    cpu_rd_en = 1; tick();
    check("R5", "empty read data", 32'(cpu_rd_data), 0);
    check("R5", "rx_unf", 32'(rx_unf), 1);
    do_clear();
    size_wr_en = 1; size_wr_data = 6'd1; tick();
    for (int i = 0; i < 2; i++) begin
      eng_push = 1; eng_push_data = pat(i, 2); tick();
      check("R7", "mrx floor", 32'(size_q), 0);
    end
    do_clear();

    // slave receive: size mirrors occupancy
    mode = 2'b01;
    tick();
    for (int k = 1; k <= 16; k++) begin
      eng_push = 1; eng_push_data = pat(k, 3); tick();
      check("R9", "srx size fill", 32'(size_q), 32'(k));
      check("R10", "thresh srx", 32'(thresh_evt), (k == 14) ? 1 : 0);
    end
    size_wr_en = 1; size_wr_data = 6'd9; tick();
    check("R9", "size write ignored", 32'(size_q), 16);
    cpu_wr_en = 1; cpu_wr_data = 8'h55; tick();
    check("R13", "cpu write ignored srx", 32'(size_q), 16);
    for (int j = 1; j <= 16; j++) begin
      cpu_rd_en = 1; tick();
      check("R9", "srx size drain", 32'(size_q), 32'(16 - j));
      check("R2", "srx order", 32'(cpu_rd_data), 32'(pat(j, 3)));
    end
    // refill past threshold again: pulse repeats only on a new arrival
    for (int k = 1; k <= 15; k++) begin
      eng_push = 1; eng_push_data = pat(k, 4); tick();
      check("R10", "thresh refill", 32'(thresh_evt), (k == 14) ? 1 : 0);
    end
    cpu_rd_en = 1; tick();
    check("R10", "thresh on drain to 14", 32'(thresh_evt), 1);
    do_clear();

    // slave transmit: leftover bytes captured at end
    mode = 2'b00;
    for (int i = 0; i < 5; i++) begin
      cpu_wr_en = 1; cpu_wr_data = pat(i, 5); tick();
    end
    eng_push = 1; eng_push_data = 8'h99; tick();
    cpu_rd_en = 1; tick();
    for (int i = 0; i < 2; i++) begin
      check("R2", "stx order", 32'(eng_pop_data), 32'(pat(i, 5)));
      eng_pop = 1; tick();
    end
    check("R8", "size before done", 32'(size_q), 0);
    eng_done = 1; tick();
    check("R8", "leftover", 32'(size_q), 3);
    check("R13", "stx head after foreign strobes", 32'(eng_pop_data), 32'(pat(2, 5)));
    check("R12", "stx tx_dv", 32'(tx_dv), 1);
    do_clear();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule